// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on a single asynchronous serial line. It has two storage stages: a holding register that software fills, and a frame register that the serializer shifts out. A write pulse loads the holding register and clears the empty flag. When the serializer is idle and sees the flag cleared, it copies the byte into its frame register, sets the flag again and starts the frame. Software can therefore queue the next byte while the current one is still on the line.

At the start of each frame's first stop bit the serializer samples the empty flag. If a new byte is waiting, it takes that byte and starts the next frame straight after the last stop bit, so there is no idle gap. If no byte is waiting, it sets the transmit-end flag and the line returns to mark (logic 1).

Each flag drives a level interrupt request that is gated by its own enable. Format inputs select 7 or 8 data bits, an optional bit slot that carries parity or a multiprocessor marker, and 1 or 2 stop bits. Bit timing comes from an external baud tick. Each bit lasts `TICKS_PER_BIT` ticks.

Top module: `uart_dbtx`

## Requirements
- R1: After reset `txd` is 1, `empty_flag` is 1 and `end_flag` is 1.
- R2: A cycle with `wr_en` high loads `wr_data` into the holding register. After that clock edge `empty_flag` is 0 and `end_flag` is 0.
- R3: While idle, if `empty_flag` is 0 (and no write arrives in the same cycle), the next clock edge starts a frame. `txd` becomes 0 (the start bit) and `empty_flag` becomes 1.
- R4: A frame is sent in this order: start bit 0, then the data bits least significant first (bits 0..6 when `fmt_seven`=1, bits 0..7 otherwise), then the optional slot bit, then the stop bits at 1 (two when `fmt_two_stop`=1, one otherwise).
- R5: The slot bit is present when `fmt_mp_en`=1 or `fmt_par_en`=1. With `fmt_mp_en`=1 it carries `fmt_mp_bit`, and this takes precedence over parity. Otherwise it is the parity of the data bits only. It is even parity when `fmt_par_odd`=0, so that the data plus the parity bit hold an even number of ones, and odd parity when `fmt_par_odd`=1.
- R6: Each bit lasts exactly `TICKS_PER_BIT` baud ticks. While a frame is in progress, `txd` does not change in a cycle without `baud_tick`.
- R7: If `empty_flag` is 0 at the start of the first stop bit, the waiting byte is taken (`empty_flag` becomes 1). Its start bit begins exactly when the last stop bit ends, so the two frame starts are frame-length × `TICKS_PER_BIT` ticks apart.
- R8: If `empty_flag` is 1 at the start of the first stop bit, `end_flag` becomes 1 on that clock edge. After the stop bits `txd` stays at 1.
- R9: A write while `empty_flag` is 0 replaces the waiting byte. The frame already on the line is not altered, and only the latest byte is sent next.
- R10: `irq_empty` equals `empty_flag` AND `tx_int_en`, and `irq_end` equals `end_flag` AND `end_int_en`, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| tx_int_en | input | 1 | Enable for the data-empty request |
| end_int_en | input | 1 | Enable for the transmit-end request |
| fmt_seven | input | 1 | 1: 7 data bits, 0: 8 data bits |
| fmt_par_en | input | 1 | Parity slot enable |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even parity |
| fmt_mp_en | input | 1 | Slot carries the multiprocessor bit |
| fmt_mp_bit | input | 1 | Value of the multiprocessor bit |
| fmt_two_stop | input | 1 | 1: two stop bits, 0: one |
| baud_tick | input | 1 | Baud-rate tick, one cycle wide |
| txd | output | 1 | Serial output line, registered |
| empty_flag | output | 1 | Holding register can take a byte |
| end_flag | output | 1 | Transmission has ended, line idle |
| irq_empty | output | 1 | Data-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
A wrong bit position or a stale frame register shows on `txd` within one frame. The bench decodes every frame at mid-bit and compares each one with a frame it builds from the written byte and the format. A mistake in the stop-bit decision moves the next start bit or the `end_flag` edge. The bench measures both to the exact cycle, so an early or late decision shows within one bit period. A missed transfer shows as a frame that never appears, and an extra transfer as a frame that was never queued; both are found by the count of frames left over at the end.

// File: rtl/uart_dbtx_pkg.sv
package uart_dbtx_pkg;

   localparam int DATA_BITS  = 8;
   localparam int SLOT_BITS  = 1;
   localparam int STOP_MAX   = 2;
   localparam int FRAME_BITS = 1 + DATA_BITS + SLOT_BITS + STOP_MAX;
   localparam int POS_W      = $clog2(FRAME_BITS);

   typedef struct packed {
      logic seven;
      logic par_en;
      logic par_odd;
      logic mp_en;
      logic mp_val;
      logic two_stop;
   } tx_fmt_t;

   typedef struct packed {
      logic [FRAME_BITS-1:0] bits;
      logic [POS_W-1:0]      last;
      logic [POS_W-1:0]      stop_at;
   } tx_frame_t;

   // Lay out one frame: bit 0 goes out first.
   function automatic tx_frame_t build_frame(logic [DATA_BITS-1:0] d, tx_fmt_t f);
      tx_frame_t fr;
      int        n;
      int        pos;
      logic      par;
      fr.bits    = '1;
      fr.bits[0] = 1'b0;
      n          = f.seven ? DATA_BITS - 1 : DATA_BITS;
      par        = f.par_odd;
      for (int i = 0; i < DATA_BITS; i++) begin
         if (i < n) begin
            fr.bits[1 + i] = d[i];
            par            = par ^ d[i];
         end
      end
      pos = 1 + n;
      if (f.mp_en) begin
         fr.bits[pos] = f.mp_val;
         pos          = pos + 1;
      end else if (f.par_en) begin
         fr.bits[pos] = par;
         pos          = pos + 1;
      end
      fr.stop_at = POS_W'(pos);
      fr.last    = POS_W'(pos + (f.two_stop ? 1 : 0));
      return fr;
   endfunction

endpackage

// File: rtl/uart_dbtx_timer.sv
module uart_dbtx_timer #(
   parameter int TICKS_PER_BIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic tick,
   output logic bit_done
);

   generate
      if (TICKS_PER_BIT < 1) begin : g_bad_ticks
         $error("uart_dbtx_timer: TICKS_PER_BIT must be at least 1");
      end

      if (TICKS_PER_BIT == 1) begin : g_direct
         logic unused_restart;
         assign unused_restart = restart;
         assign bit_done       = run & tick;
      end else begin : g_count
         localparam int CW = $clog2(TICKS_PER_BIT);
         localparam logic [CW-1:0] TOP = CW'(TICKS_PER_BIT - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart) begin
               cnt_q <= '0;
            end else if (run && tick) begin
               cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
            end
         end

         assign bit_done = run && tick && (cnt_q == TOP);
      end
   endgenerate

endmodule

// File: rtl/uart_dbtx_hold.sv
module uart_dbtx_hold
   import uart_dbtx_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DATA_BITS-1:0] wr_data,
   input  logic                 take,
   input  logic                 end_set,
   output logic [DATA_BITS-1:0] hold_q,
   output logic                 empty_q,
   output logic                 end_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         empty_q <= 1'b1;
         end_q   <= 1'b1;
      end else begin
         if (wr_en) begin
            hold_q <= wr_data;
         end
         // A write in the same cycle as a transfer leaves fresh data waiting.
         if (wr_en) begin
            empty_q <= 1'b0;
         end else if (take) begin
            empty_q <= 1'b1;
         end
         if (wr_en) begin
            end_q <= 1'b0;
         end else if (end_set) begin
            end_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_dbtx_ser.sv
module uart_dbtx_ser
   import uart_dbtx_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  tx_fmt_t              fmt,
   input  logic [DATA_BITS-1:0] hold_q,
   input  logic                 empty_q,
   input  logic                 bit_done,
   output logic                 take,
   output logic                 end_set,
   output logic                 restart,
   output logic                 busy,
   output logic                 txd
);

   tx_frame_t        frm_q;
   tx_frame_t        pend_q;
   tx_frame_t        fresh;
   logic             pend_v;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_nx;
   logic             busy_q;
   logic             txd_q;
   logic             at_last;

   assign fresh   = build_frame(hold_q, fmt);
   assign pos_nx  = pos_q + 1'b1;
   assign at_last = (pos_q == frm_q.last);

   always_comb begin
      take    = 1'b0;
      end_set = 1'b0;
      restart = 1'b0;
      if (!busy_q) begin
         if (!empty_q) begin
            take    = 1'b1;
            restart = 1'b1;
         end
      end else if (bit_done && !at_last && (pos_nx == frm_q.stop_at)) begin
         // Decision point: first stop bit is about to begin.
         if (!empty_q) begin
            take = 1'b1;
         end else begin
            end_set = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_q  <= '0;
         pend_q <= '0;
         pend_v <= 1'b0;
         pos_q  <= '0;
         busy_q <= 1'b0;
         txd_q  <= 1'b1;
      end else if (!busy_q) begin
         if (!empty_q) begin
            frm_q  <= fresh;
            pos_q  <= '0;
            busy_q <= 1'b1;
            txd_q  <= 1'b0;
         end
      end else if (bit_done) begin
         if (at_last) begin
            if (pend_v) begin
               frm_q  <= pend_q;
               pend_v <= 1'b0;
               pos_q  <= '0;
               txd_q  <= 1'b0;
            end else begin
               busy_q <= 1'b0;
               txd_q  <= 1'b1;
            end
         end else begin
            pos_q <= pos_nx;
            txd_q <= frm_q.bits[pos_nx];
            if (take) begin
               pend_q <= fresh;
               pend_v <= 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign txd  = txd_q;

endmodule

// File: rtl/uart_dbtx.sv
module uart_dbtx
   import uart_dbtx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       tx_int_en,
   input  logic       end_int_en,
   input  logic       fmt_seven,
   input  logic       fmt_par_en,
   input  logic       fmt_par_odd,
   input  logic       fmt_mp_en,
   input  logic       fmt_mp_bit,
   input  logic       fmt_two_stop,
   input  logic       baud_tick,
   output logic       txd,
   output logic       empty_flag,
   output logic       end_flag,
   output logic       irq_empty,
   output logic       irq_end
);

   tx_fmt_t              fmt;
   logic [DATA_BITS-1:0] hold_q;
   logic                 take;
   logic                 end_set;
   logic                 restart;
   logic                 bit_done;
   logic                 ser_busy;

   assign fmt = '{seven: fmt_seven, par_en: fmt_par_en, par_odd: fmt_par_odd,
                  mp_en: fmt_mp_en, mp_val: fmt_mp_bit, two_stop: fmt_two_stop};

   uart_dbtx_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .end_set (end_set),
      .hold_q  (hold_q),
      .empty_q (empty_flag),
      .end_q   (end_flag)
   );

   uart_dbtx_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .run      (ser_busy),
      .tick     (baud_tick),
      .bit_done (bit_done)
   );

   uart_dbtx_ser u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt      (fmt),
      .hold_q   (hold_q),
      .empty_q  (empty_flag),
      .bit_done (bit_done),
      .take     (take),
      .end_set  (end_set),
      .restart  (restart),
      .busy     (ser_busy),
      .txd      (txd)
   );

   assign irq_empty = empty_flag & tx_int_en;
   assign irq_end   = end_flag & end_int_en;

endmodule

// File: rtl/uart_dbtx_checker.sv
module uart_dbtx_checker (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic baud_tick,
   input logic txd,
   input logic empty_flag,
   input logic end_flag,
   input logic busy
);

   assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!empty_flag && !end_flag));

   assert_take_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !empty_flag && !wr_en) |=> (busy && !txd && empty_flag));

   assert_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick) |=> $stable(txd));

   assert_idle_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   assert_end_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(end_flag) |-> empty_flag);

endmodule

bind uart_dbtx uart_dbtx_checker i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .baud_tick  (baud_tick),
   .txd        (txd),
   .empty_flag (empty_flag),
   .end_flag   (end_flag),
   .busy       (ser_busy)
);

// File: tb/test_uart_dbtx.sv
`timescale 1ns/1ps
module test_uart_dbtx;

   localparam int TPB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic tx_int_en = 1'b0;
   logic end_int_en = 1'b0;
   logic f_seven = 1'b0;
   logic f_par = 1'b0;
   logic f_odd = 1'b0;
   logic f_mp = 1'b0;
   logic f_mpv = 1'b0;
   logic f_two = 1'b0;
   logic baud_tick = 1'b1;
   logic txd;
   logic empty_flag;
   logic end_flag;
   logic irq_empty;
   logic irq_end;

   int n_tests = 0;
   int n_fail = 0;
   int cyc = 0;
   logic mon_on = 1'b1;
   logic done = 1'b0;

   logic [7:0] exp_d [0:1023];
   logic       exp_b2b [0:1023];
   int wr_ptr = 0;
   int rd_ptr = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uart_dbtx #(.TICKS_PER_BIT(TPB)) i_uart_dbtx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tx_int_en(tx_int_en), .end_int_en(end_int_en),
      .fmt_seven(f_seven), .fmt_par_en(f_par), .fmt_par_odd(f_odd),
      .fmt_mp_en(f_mp), .fmt_mp_bit(f_mpv), .fmt_two_stop(f_two),
      .baud_tick(baud_tick), .txd(txd), .empty_flag(empty_flag),
      .end_flag(end_flag), .irq_empty(irq_empty), .irq_end(irq_end)
   );

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int exp_len();
      int n = f_seven ? 7 : 8;
      return 1 + n + ((f_mp || f_par) ? 1 : 0) + (f_two ? 2 : 1);
   endfunction

   function automatic logic exp_bit(int b, logic [7:0] d);
      int   n = f_seven ? 7 : 8;
      logic p;
      if (b == 0) return 1'b0;
      if (b <= n) return d[b-1];
      if (b == n + 1 && (f_mp || f_par)) begin
         if (f_mp) return f_mpv;
         p = f_odd;
         for (int i = 0; i < n; i++) p = p ^ d[i];
         return p;
      end
      return 1'b1;
   endfunction

   // Line monitor: decodes each frame at mid-bit (R4, R5, R7)
   initial begin
      int st;
      int prev_st;
      prev_st = -1000;
      forever begin
         @(negedge clk);
         if (mon_on && txd === 1'b0) begin
            logic [11:0] got;
            logic [11:0] ev;
            logic [7:0]  d;
            logic        b2b;
            int          len;
            st  = cyc;
            got = '1;
            ev  = '1;
            repeat (2) @(negedge clk);
            if (rd_ptr < wr_ptr) begin
               d   = exp_d[rd_ptr];
               b2b = exp_b2b[rd_ptr];
            end else begin
               d   = 8'h00;
               b2b = 1'b0;
               check(1'b0, "R3 unexpected frame", 32'(rd_ptr), 32'(wr_ptr));
            end
            rd_ptr++;
            len = exp_len();
            for (int b = 0; b < len; b++) begin
               if (b > 0) repeat (TPB) @(negedge clk);
               got[b] = txd;
               ev[b]  = exp_bit(b, d);
            end
            check(got == ev, "R4/R5 frame bits (R4 R5)", 32'(got), 32'(ev));
            if (b2b) begin
               check(st - prev_st == len * TPB, "R7 back-to-back gap", 32'(st - prev_st), 32'(len * TPB));
            end
            prev_st = st;
         end
      end
   end

   task automatic push(input logic [7:0] d, input logic b2b);
      exp_d[wr_ptr]   = d;
      exp_b2b[wr_ptr] = b2b;
      wr_ptr++;
   endtask

   task automatic write_raw(input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(end_flag && empty_flag));
      repeat (3 * TPB + 3) @(negedge clk);
   endtask

   task automatic set_fmt(input logic s, input logic p, input logic o, input logic m, input logic mv, input logic t);
      f_seven = s; f_par = p; f_odd = o; f_mp = m; f_mpv = mv; f_two = t;
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic ok;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(txd === 1'b1, "R1 txd reset", 32'(txd), 1);
      check(empty_flag === 1'b1, "R1 empty reset", 32'(empty_flag), 1);
      check(end_flag === 1'b1, "R1 end reset", 32'(end_flag), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(txd === 1'b1 && empty_flag === 1'b1 && end_flag === 1'b1, "R1 after release",
            32'({txd, empty_flag, end_flag}), 32'h7);
      check(irq_empty === 1'b0 && irq_end === 1'b0, "R10 disabled requests",
            32'({irq_empty, irq_end}), 0);
      end_int_en = 1'b1;
      tx_int_en  = 1'b1;
      #1;
      check(irq_empty === 1'b1 && irq_end === 1'b1, "R10 enabled requests",
            32'({irq_empty, irq_end}), 32'h3);

      // Directed single frame, 8 data, no slot, 1 stop
      set_fmt(0, 0, 0, 0, 0, 0);
      push(8'hA5, 1'b0);
      write_raw(8'hA5);
      check(empty_flag === 1'b0 && end_flag === 1'b0, "R2 write clears flags",
            32'({empty_flag, end_flag}), 0);
      check(irq_empty === 1'b0 && irq_end === 1'b0, "R10 requests follow flags",
            32'({irq_empty, irq_end}), 0);
      @(negedge clk);
      check(txd === 1'b0 && empty_flag === 1'b1, "R3 transfer and start bit",
            32'({txd, empty_flag}), 32'h1);
      check(irq_empty === 1'b1, "R10 empty request", 32'(irq_empty), 1);
      repeat (35) @(negedge clk);
      check(end_flag === 1'b0, "R8 end before stop bit", 32'(end_flag), 0);
      @(negedge clk);
      check(end_flag === 1'b1 && txd === 1'b1, "R8 end at stop bit", 32'({end_flag, txd}), 32'h3);
      check(irq_end === 1'b1, "R10 end request", 32'(irq_end), 1);
      end_int_en = 1'b0;
      #1;
      check(irq_end === 1'b0, "R10 end request gated", 32'(irq_end), 0);
      end_int_en = 1'b1;
      wait_idle();
      ok = 1'b1;
      repeat (20) begin
         @(negedge clk);
         if (txd !== 1'b1) ok = 1'b0;
      end
      check(ok, "R8 mark idle", 32'(txd), 1);

      // Back-to-back, even parity
      set_fmt(0, 1, 0, 0, 0, 0);
      push(8'h3C, 1'b0);
      write_raw(8'h3C);
      repeat (2) @(negedge clk);
      push(8'hC1, 1'b1);
      write_raw(8'hC1);
      wait_idle();

      // R9 overwrite of waiting byte, odd parity, 7 bits, 2 stop
      set_fmt(1, 1, 1, 0, 0, 1);
      push(8'h55, 1'b0);
      write_raw(8'h55);
      write_raw(8'h12);
      write_raw(8'h6E);
      push(8'h6E, 1'b1);
      wait_idle();
      check(rd_ptr == wr_ptr, "R9 only latest byte sent", 32'(rd_ptr), 32'(wr_ptr));

      // R6 no progress without baud ticks
      mon_on = 1'b0;
      set_fmt(0, 0, 0, 0, 0, 0);
      baud_tick = 1'b0;
      write_raw(8'h80);
      @(negedge clk);
      ok = 1'b1;
      repeat (20) begin
         @(negedge clk);
         if (txd !== 1'b0) ok = 1'b0;
      end
      check(ok, "R6 start bit held without ticks", 32'(txd), 0);
      baud_tick = 1'b1;
      repeat (TPB - 1) @(negedge clk);
      check(txd === 1'b0, "R6 start bit still on", 32'(txd), 0);
      @(negedge clk);
      check(txd === 1'b0, "R6 first data bit D0=0", 32'(txd), 0);
      wait_idle();
      mon_on = 1'b1;

      // Constrained random bursts across formats (R4 R5 R7)
      void'($urandom(32'd1234));
      for (int it = 0; it < 40; it++) begin
         int nb;
         set_fmt(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom), 1'($urandom));
         nb = 1 + ($urandom % 3);
         for (int k = 0; k < nb; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            do @(negedge clk); while (!empty_flag);
            push(d, k > 0);
            write_raw(d);
         end
         wait_idle();
      end

      // Corner: multiprocessor slot wins over parity
      set_fmt(0, 1, 1, 1, 1, 0);
      push(8'hFF, 1'b0);
      write_raw(8'hFF);
      wait_idle();
      set_fmt(0, 1, 0, 1, 0, 1);
      push(8'h00, 1'b0);
      write_raw(8'h00);
      wait_idle();

      check(rd_ptr == wr_ptr, "R4 all queued frames sent", 32'(rd_ptr), 32'(wr_ptr));
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule